// File: doc/BRIEF.md
# Multi-CPU device interrupt router

This block collects up to 64 device interrupt lines into one shared pending-request vector and steers them to up to four processors. Each processor owns a mask vector. It also owns a stored masked-result vector, which always equals its mask ANDed with the pending vector. The OR of that result drives the processor's level-sensitive interrupt output.

Devices raise and drop lines through two dedicated pulse inputs. Each input carries a valid bit and a line index. Software reaches the registers through a 64-bit register port. The port takes a byte offset, a write flag and write data, and returns read data and an error pulse one cycle after the request.

Each mask can be reached two ways:
- Normal map: the register index is the offset shifted right by 6.
- Alternate mask map: offset bit 20 is set and the CPU number sits in offset bits [9:4].

Offset bit 21 selects a matching alternate read-only map for the masked results.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset, all of the following read as zero: the pending vector, every mask, every masked result, `cpu_irq`, `rd_valid` and `err_pulse`.
- R2: A post pulse on line n sets bit n of the pending vector at that clock edge. A read of normal index 1 (offset 0x40) returns the pending vector.
- R3: A clear pulse on line n clears pending bit n when it is set. A clear of a line that is not pending changes nothing.
- R4: A post and a clear of the same line in the same cycle leave that line pending.
- R5: The masked result of CPU c equals its mask AND the pending vector after every edge. It reads at normal index 8+c (offset 0x200+0x40*c). It also reads in the alternate map at offset bit 21 set, with c in bits [9:4].
- R6: The mask of CPU c reads and writes at normal index 2+c (offset 0x80+0x40*c). The same mask reads and writes in the alternate map at offset bit 20 set, with c in bits [9:4]. Bit 20 takes priority over bit 21.
- R7: `cpu_irq[c]` equals the OR of CPU c's masked result as held one cycle earlier.
  - A change at edge k shows at `cpu_irq` after edge k+1.
- R8: A mask write that drops a bit contributing to the result deasserts that CPU's output. A mask write that sets a bit matching a pending line asserts it.
- R9: A write to the pending vector, to a normal-map result index or to the alternate result map raises `err_pulse` for one cycle. Such a write changes no register.
- R10: Each of the following is an unsupported access:
  - an unlisted normal index;
  - an offset with bits [2:0] nonzero, which makes it other than 64-bit aligned;
  - a normal-map offset with bits [5:3] nonzero;
  - an alternate offset with bits [3:0] or [19:10] nonzero;
  - an alternate CPU number of NUM_CPUS or more;
  - any offset bit above 21 set.

  An unsupported access pulses `err_pulse`, gives no `rd_valid` and leaves every register unchanged.
- R11: A legal read returns `rd_valid` high and its data one cycle after the request. The data reflects the state before any update made at the request's own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset from block base |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 64 | Read data |
| err_pulse | output | 1 | One-cycle pulse for an unsupported access |
| post_valid | input | 1 | Post pulse for a device line |
| post_line | input | LINE_W | Line index to post |
| clr_valid | input | 1 | Clear pulse for a device line |
| clr_line | input | LINE_W | Line index to clear |
| cpu_irq | output | NUM_CPUS | Per-CPU device interrupt level |

## Verification
Two functions can fall in the same cycle and are provoked on purpose:
- A line post and a line clear can target the same index. The bench pulses both together and judges the result by reading the pending vector and watching `cpu_irq`. The post must win.
- A register read can coincide with a line post. The bench reads the pending vector in the very cycle a new line is posted. The returned data must lack the new bit, and a follow-up read must show it.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // Normal-map register indices (byte offset >> 6)
  localparam int IDX_PEND  = 1;
  localparam int IDX_MASK0 = 2;
  localparam int IDX_RES0  = 8;
  // Offset bits selecting the alternate maps
  localparam int ALT_MASK_BIT = 20;
  localparam int ALT_RES_BIT  = 21;
  localparam int IDX_W        = ALT_MASK_BIT - 6;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2,
    SEL_RES  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 24,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output rd_sel_e           sel,
  output logic [CPU_W-1:0]  cpu,
  output logic              wr_mask,
  output logic              bad
);
  logic [IDX_W-1:0] idx;
  logic [5:0]       alt_cpu;
  logic             upper_set;

  assign idx       = req_addr[ALT_MASK_BIT-1:6];
  assign alt_cpu   = req_addr[9:4];
  assign upper_set = |req_addr[ADDR_W-1:ALT_RES_BIT+1];

  always_comb begin
    sel     = SEL_NONE;
    cpu     = '0;
    wr_mask = 1'b0;
    bad     = 1'b0;
    if (req_valid) begin
      if (upper_set || (req_addr[2:0] != 3'd0)) begin
        bad = 1'b1;
      end else if (req_addr[ALT_MASK_BIT] || req_addr[ALT_RES_BIT]) begin
        if ((req_addr[3:0] != 4'd0) || (req_addr[ALT_MASK_BIT-1:10] != '0) ||
            (int'(alt_cpu) >= NUM_CPUS)) begin
          bad = 1'b1;
        end else if (req_addr[ALT_MASK_BIT]) begin
          cpu     = CPU_W'(alt_cpu);
          sel     = SEL_MASK;
          wr_mask = req_write;
        end else if (req_write) begin
          bad = 1'b1;
        end else begin
          cpu = CPU_W'(alt_cpu);
          sel = SEL_RES;
        end
      end else if (req_addr[5:3] != 3'd0) begin
        bad = 1'b1;
      end else if (int'(idx) == IDX_PEND) begin
        if (req_write) bad = 1'b1;
        else           sel = SEL_PEND;
      end else if ((int'(idx) >= IDX_MASK0) && (int'(idx) < IDX_MASK0 + NUM_CPUS)) begin
        cpu     = CPU_W'(int'(idx) - IDX_MASK0);
        sel     = SEL_MASK;
        wr_mask = req_write;
      end else if ((int'(idx) >= IDX_RES0) && (int'(idx) < IDX_RES0 + NUM_CPUS)) begin
        if (req_write) bad = 1'b1;
        else begin
          cpu = CPU_W'(int'(idx) - IDX_RES0);
          sel = SEL_RES;
        end
      end else begin
        bad = 1'b1;
      end
    end
  end

  // R10
  always_comb begin
    decode_excl_chk: assert (!(bad && wr_mask));
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 post_valid,
  input  logic [LINE_W-1:0]    post_line,
  input  logic                 clr_valid,
  input  logic [LINE_W-1:0]    clr_line,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] pend_d
);
  // Clear applied first, post last, so a same-line post wins
  always_comb begin
    pend_d = pend_q;
    if (clr_valid && (int'(clr_line) < NUM_LINES) && pend_q[clr_line])
      pend_d[clr_line] = 1'b0;
    if (post_valid && (int'(post_line) < NUM_LINES))
      pend_d[post_line] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  // R2
  post_set_chk: assert property (@(posedge clk) disable iff (rst)
    post_valid |=> pend_q[$past(post_line)]);

  // R4
  post_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (post_valid && clr_valid && (post_line == clr_line)) |=> pend_q[$past(clr_line)]);

  // R3
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !(post_valid && (post_line == clr_line))) |=> !pend_q[$past(clr_line)]);

  // R3
  spurious_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !post_valid && !pend_q[clr_line]) |=> $stable(pend_q));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic [NUM_LINES-1:0] pend_q,
  input  logic [NUM_LINES-1:0] pend_d,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] result_q,
  output logic                 irq_q
);
  logic [NUM_LINES-1:0] mask_d;

  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      result_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      result_q <= mask_d & pend_d;
      irq_q    <= |result_q;
    end
  end

  // R5
  result_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (result_q == (mask_q & pend_q)));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == (|$past(result_q))));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  parameter int ADDR_W    = 24,
  localparam int DATA_W   = 64,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                err_pulse,
  input  logic                post_valid,
  input  logic [LINE_W-1:0]   post_line,
  input  logic                clr_valid,
  input  logic [LINE_W-1:0]   clr_line,
  output logic [NUM_CPUS-1:0] cpu_irq
);
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] mask_arr   [NUM_CPUS];
  logic [NUM_LINES-1:0] result_arr [NUM_CPUS];
  rd_sel_e              sel;
  logic [CPU_W-1:0]     dec_cpu;
  logic                 wr_mask, bad;
  logic [DATA_W-1:0]    rd_mux;
  logic                 rd_valid_q, err_q;
  logic [DATA_W-1:0]    rd_data_q;

  irq_reg_decode #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .sel       (sel),
    .cpu       (dec_cpu),
    .wr_mask   (wr_mask),
    .bad       (bad)
  );

  irq_pending #(.NUM_LINES(NUM_LINES)) u_pending (
    .clk        (clk),
    .rst        (rst),
    .post_valid (post_valid),
    .post_line  (post_line),
    .clr_valid  (clr_valid),
    .clr_line   (clr_line),
    .pend_q     (pend_q),
    .pend_d     (pend_d)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_slice #(.NUM_LINES(NUM_LINES)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .mask_we    (wr_mask && (dec_cpu == CPU_W'(c))),
      .mask_wdata (req_wdata[NUM_LINES-1:0]),
      .pend_q     (pend_q),
      .pend_d     (pend_d),
      .mask_q     (mask_arr[c]),
      .result_q   (result_arr[c]),
      .irq_q      (cpu_irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_PEND: rd_mux[NUM_LINES-1:0] = pend_q;
      SEL_MASK: rd_mux[NUM_LINES-1:0] = mask_arr[dec_cpu];
      SEL_RES:  rd_mux[NUM_LINES-1:0] = result_arr[dec_cpu];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      err_q      <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= req_valid && !req_write && !bad;
      err_q      <= bad;
      rd_data_q  <= rd_mux;
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
  assign err_pulse = err_q;

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !rd_valid_q);

  // R11
  rd_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_q |-> $past(req_valid && !req_write));
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [63:0] data;
    logic        exp_err;
    logic        exp_rdv;
    logic [63:0] exp_data;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R6 mask access through both maps
    '{1'b1, 24'h000080, 64'h000000000000F0F0, 1'b0, 1'b0, 64'h0, 4'd6},
    '{1'b0, 24'h000080, 64'h0, 1'b0, 1'b1, 64'h000000000000F0F0, 4'd6},
    '{1'b1, 24'h100010, 64'h00000000000000FF, 1'b0, 1'b0, 64'h0, 4'd6},
    '{1'b0, 24'h0000C0, 64'h0, 1'b0, 1'b1, 64'h00000000000000FF, 4'd6},
    '{1'b0, 24'h100000, 64'h0, 1'b0, 1'b1, 64'h000000000000F0F0, 4'd6},
    '{1'b1, 24'h000100, 64'h8000000000000001, 1'b0, 1'b0, 64'h0, 4'd6},
    '{1'b1, 24'h000140, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b0, 64'h0, 4'd6},
    '{1'b0, 24'h100030, 64'h0, 1'b0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 4'd6},
    // R9 writes to read-only registers
    '{1'b1, 24'h000040, 64'h1, 1'b1, 1'b0, 64'h0, 4'd9},
    '{1'b0, 24'h000040, 64'h0, 1'b0, 1'b1, 64'h0, 4'd9},
    '{1'b1, 24'h000200, 64'hFF, 1'b1, 1'b0, 64'h0, 4'd9},
    '{1'b1, 24'h200010, 64'hFF, 1'b1, 1'b0, 64'h0, 4'd9},
    // R5 alternate result read
    '{1'b0, 24'h200010, 64'h0, 1'b0, 1'b1, 64'h0, 4'd5},
    // R10 unsupported accesses
    '{1'b0, 24'h000000, 64'h0, 1'b1, 1'b0, 64'h0, 4'd10},
    '{1'b0, 24'h000084, 64'h0, 1'b1, 1'b0, 64'h0, 4'd10},
    '{1'b1, 24'h100040, 64'h0, 1'b1, 1'b0, 64'h0, 4'd10},
    '{1'b0, 24'h000300, 64'h0, 1'b1, 1'b0, 64'h0, 4'd10},
    '{1'b1, 24'h400080, 64'h0, 1'b1, 1'b0, 64'h0, 4'd10},
    '{1'b0, 24'h000080, 64'h0, 1'b0, 1'b1, 64'h000000000000F0F0, 4'd10},
    '{1'b0, 24'h0000C0, 64'h0, 1'b0, 1'b1, 64'h00000000000000FF, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rd_valid, err_pulse;
  logic [63:0] rd_data;
  logic        post_valid = 1'b0, clr_valid = 1'b0;
  logic [5:0]  post_line = '0, clr_line = '0;
  logic [3:0]  cpu_irq;

  int errors = 0;
  int checks = 0;
  logic        got_rdv, got_err;
  logic [63:0] got_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_pulse(err_pulse), .post_valid(post_valid), .post_line(post_line),
    .clr_valid(clr_valid), .clr_line(clr_line), .cpu_irq(cpu_irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle with optional bus request and optional post/clear pulses
  task automatic cycle(input logic rv, input logic wr, input logic [23:0] a,
                       input logic [63:0] d, input logic pv, input logic [5:0] pl,
                       input logic cv, input logic [5:0] cl);
    @(negedge clk);
    req_valid = rv; req_write = wr; req_addr = a; req_wdata = d;
    post_valid = pv; post_line = pl; clr_valid = cv; clr_line = cl;
    @(posedge clk);
    #1;
    got_rdv = rd_valid; got_err = err_pulse; got_data = rd_data;
    req_valid = 1'b0; post_valid = 1'b0; clr_valid = 1'b0;
  endtask

  task automatic bus(input logic wr, input logic [23:0] a, input logic [63:0] d);
    cycle(1'b1, wr, a, d, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  task automatic rd_chk(input string tag, input logic [23:0] a, input logic [63:0] exp);
    bus(1'b0, a, 64'h0);
    check({tag, " rd_valid"}, {63'h0, got_rdv}, 64'h1);
    check({tag, " data"}, got_data, exp);
  endtask

  task automatic idle;
    cycle(1'b0, 1'b0, 24'h0, 64'h0, 1'b0, 6'd0, 1'b0, 6'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1 cpu_irq", {60'h0, cpu_irq}, 64'h0);
    check("R1 rd_valid", {63'h0, rd_valid}, 64'h0);
    check("R1 err_pulse", {63'h0, err_pulse}, 64'h0);
    rd_chk("R1 pending", 24'h000040, 64'h0);
    rd_chk("R1 result0", 24'h000200, 64'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].wr, VECS[i].addr, VECS[i].data);
      check($sformatf("R%0d vec%0d err", VECS[i].req, i), {63'h0, got_err}, {63'h0, VECS[i].exp_err});
      check($sformatf("R%0d vec%0d rdv", VECS[i].req, i), {63'h0, got_rdv}, {63'h0, VECS[i].exp_rdv});
      if (VECS[i].exp_rdv)
        check($sformatf("R%0d vec%0d data", VECS[i].req, i), got_data, VECS[i].exp_data);
    end
    // masks: m0=F0F0 m1=FF m2=8000..0001 m3=all ones
    check("R9 irq untouched", {60'h0, cpu_irq}, 64'h0);

    // R2 post line 0; R7 output lags result by one cycle
    cycle(1'b0, 1'b0, 24'h0, 64'h0, 1'b1, 6'd0, 1'b0, 6'd0);
    check("R7 irq before lag", {60'h0, cpu_irq}, 64'h0);
    idle();
    check("R7 irq after post", {60'h0, cpu_irq}, 64'hE);
    rd_chk("R2 pending", 24'h000040, 64'h1);
    rd_chk("R5 alt result2", 24'h200020, 64'h1);
    rd_chk("R5 result0", 24'h000200, 64'h0);

    // R3 spurious clear of line 5
    cycle(1'b0, 1'b0, 24'h0, 64'h0, 1'b0, 6'd0, 1'b1, 6'd5);
    idle();
    rd_chk("R3 spurious pending", 24'h000040, 64'h1);
    check("R3 spurious irq", {60'h0, cpu_irq}, 64'hE);

    // R4 post and clear of line 4 together
    cycle(1'b0, 1'b0, 24'h0, 64'h0, 1'b1, 6'd4, 1'b1, 6'd4);
    idle();
    rd_chk("R4 pending", 24'h000040, 64'h11);
    check("R4 irq", {60'h0, cpu_irq}, 64'hF);

    // R3 real clear of line 0
    cycle(1'b0, 1'b0, 24'h0, 64'h0, 1'b0, 6'd0, 1'b1, 6'd0);
    idle();
    rd_chk("R3 pending", 24'h000040, 64'h10);
    check("R3 irq", {60'h0, cpu_irq}, 64'hB);

    // R8 mask drop deasserts, mask set asserts
    bus(1'b1, 24'h0000C0, 64'h0);
    idle();
    check("R8 drop irq", {60'h0, cpu_irq}, 64'h9);
    bus(1'b1, 24'h100020, 64'h10);
    idle();
    check("R8 set irq", {60'h0, cpu_irq}, 64'hD);
    rd_chk("R8 result2", 24'h000280, 64'h10);

    // R2 top line
    cycle(1'b0, 1'b0, 24'h0, 64'h0, 1'b1, 6'd63, 1'b0, 6'd0);
    rd_chk("R2 line63", 24'h000040, 64'h8000000000000010);

    // R11 read concurrent with post returns old state
    cycle(1'b1, 1'b0, 24'h000040, 64'h0, 1'b1, 6'd1, 1'b0, 6'd0);
    check("R11 old data", got_data, 64'h8000000000000010);
    rd_chk("R11 new data", 24'h000040, 64'h8000000000000012);
    check("R11 irq", {60'h0, cpu_irq}, 64'hD);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 irq after reset", {60'h0, cpu_irq}, 64'h0);
    rd_chk("R1 pending after reset", 24'h000040, 64'h0);
    rd_chk("R1 mask0 after reset", 24'h000080, 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule